// File: doc/BRIEF.md
# Four-Operator FM Algorithm Sequencer

This block is the per-channel control of a four-operator FM voice. A pulse on `smp_start` captures the channel configuration and starts one sample period. The block then asks an external operator unit for four operator results, one request at a time. The operators are evaluated in the fixed order 1, 3, 2, 4. With each request the block supplies the 10-bit phase-modulation offset for that operator.

The offset comes from three things: the selected routing algorithm, the operator outputs the block has already stored, and, for operator 1, its own self-feedback. When operator 4 has answered, the block adds the carrier outputs together, saturates the sum to the signed 14-bit range, and presents it as the channel sample for one cycle.

The block reproduces the hardware's evaluation-order and pipelining effects. On certain modulator paths the modulated operator sees the modulator's output from the previous sample instead of the current one.

Top module: `fm_alg_seq`

## Requirements
- R1: After reset `op_req_valid`, `smp_valid` and `smp_data` are 0. The operator-1 history and all stored operator outputs are 0, so the first sample's offsets are computed from zeros.
- R2: Within one sample, requests are issued for operators 1, 3, 2, 4, encoded on `op_req_idx` as 0, 2, 1, 3. No further request follows until the next accepted start.
- R3: While a request is pending without a response, `op_req_valid` stays high and `op_req_idx` and `op_req_offset` stay constant. A response is accepted on a clock edge where both `op_req_valid` and `op_rsp_valid` are high, and the next request appears on the cycle after.
- R4: For operators 2 to 4, the offset is bits 10:1 of the signed sum of the modulator outputs, taken modulo 1024. The modulators follow the algorithm:
  - alg 0: 1→2→3→4
  - alg 1: (1+2)→3→4
  - alg 2: 1→4 and 2→3→4
  - alg 3: 1→2→4 and 3→4
  - alg 4: 1→2 and 3→4
  - alg 5: 1→2, 1→3 and 1→4
  - alg 6: 1→2
  - alg 7: no modulation
- R5: The following paths use the modulator's output from the previous sample: alg 0 (2→3), alg 1 (1→3 and 2→3), alg 2 (2→3), alg 3 (2→4) and alg 5 (1→3). Every other path uses the current sample's output.
- R6: Let F be the feedback level. When F is nonzero, operator 1's offset is the sum of its two most recent outputs, arithmetically shifted right by 10−F and taken modulo 1024. When F is 0, the offset is 0.
- R7: The channel sample is the sum of the carrier outputs, saturated to the range −8192..8191. The carriers are:
  - algs 0–3: {4}
  - alg 4: {2,4}
  - algs 5 and 6: {2,3,4}
  - alg 7: {1,2,3,4}
- R8: `smp_valid` is high for exactly the one cycle that follows acceptance of operator 4's response.
- R9: `chan_cfg` holds the algorithm in bits 2:0 and the feedback level in bits 5:3. It is captured only when a start is accepted in idle. A start while busy, a configuration change mid-sample, and a response while idle all have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_cfg | input | 6 | [2:0] algorithm, [5:3] feedback level |
| smp_start | input | 1 | Start one sample period (accepted in idle only) |
| op_req_valid | output | 1 | Operator request pending |
| op_req_idx | output | 2 | Operator being requested (0 = operator 1) |
| op_req_offset | output | 10 | Phase-modulation offset for the requested operator |
| op_rsp_valid | input | 1 | Operator result present |
| op_rsp_data | input | 14 | Signed operator output |
| smp_valid | output | 1 | Channel sample strobe |
| smp_data | output | 14 | Saturated signed channel sample |

## Verification
The assertions check the handshake and sequencing properties on every cycle:
- a request holds steady until it is answered;
- each operator index is followed by the correct next one;
- operator 4's response produces a single-cycle sample strobe with no request left pending.

The offset arithmetic and the per-algorithm routing can only be shown by the bench's scenarios, which compare the outputs against an independent model over random and directed samples. The same applies to the previous-sample paths, the averaging of the feedback history, carrier saturation at both rails, and the ignoring of start pulses, configuration changes and stray responses.

// File: rtl/fm_seq_pkg.sv
// Shared widths, types and routing tables of the FM algorithm sequencer.
// Assumes exactly four operators per channel; operator k is bit k of a mask.
package fm_seq_pkg;
    localparam int OPS   = 4;
    localparam int OUT_W = 14;
    localparam int PH_W  = 10;
    localparam int ALG_W = 3;
    localparam int FB_W  = 3;
    localparam int IDX_W = $clog2(OPS);
    localparam int CFG_W = ALG_W + FB_W;
    localparam int SUM_W = OUT_W + IDX_W;

    typedef logic signed [OUT_W-1:0] op_out_t;

    // Modulator sources of one operator and which of them are a sample late
    typedef struct packed {
        logic [OPS-1:0] src;
        logic [OPS-1:0] dly;
    } route_t;

    // Modulators feeding operator `op` (0-based) under algorithm `alg`
    function automatic route_t route_of(input logic [ALG_W-1:0] alg,
                                        input logic [IDX_W-1:0] op);
        route_t r;
        r = '0;
        case (alg)
            3'd0: begin
                if (op == 2'd1) r.src = 4'b0001;
                if (op == 2'd2) begin r.src = 4'b0010; r.dly = 4'b0010; end
                if (op == 2'd3) r.src = 4'b0100;
            end
            3'd1: begin
                if (op == 2'd2) begin r.src = 4'b0011; r.dly = 4'b0011; end
                if (op == 2'd3) r.src = 4'b0100;
            end
            3'd2: begin
                if (op == 2'd2) begin r.src = 4'b0010; r.dly = 4'b0010; end
                if (op == 2'd3) r.src = 4'b0101;
            end
            3'd3: begin
                if (op == 2'd1) r.src = 4'b0001;
                if (op == 2'd3) begin r.src = 4'b0110; r.dly = 4'b0010; end
            end
            3'd4: begin
                if (op == 2'd1) r.src = 4'b0001;
                if (op == 2'd3) r.src = 4'b0100;
            end
            3'd5: begin
                if (op != 2'd0) r.src = 4'b0001;
                if (op == 2'd2) r.dly = 4'b0001;
            end
            3'd6: begin
                if (op == 2'd1) r.src = 4'b0001;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // Operators whose outputs reach the channel sum
    function automatic logic [OPS-1:0] carriers_of(input logic [ALG_W-1:0] alg);
        case (alg)
            3'd4:        return 4'b1010;
            3'd5, 3'd6:  return 4'b1110;
            3'd7:        return 4'b1111;
            default:     return 4'b1000;
        endcase
    endfunction

    // Evaluation slot to operator: slots 0..3 visit operators 1,3,2,4
    function automatic logic [IDX_W-1:0] slot_to_op(input logic [IDX_W-1:0] slot);
        return {slot[0], slot[1]};
    endfunction
endpackage

// File: rtl/fm_seq_ctrl.sv
// Sample-period sequencer: accepts a start in idle, walks four evaluation
// slots and advances one slot per accepted response.
// Assumes the operator unit answers each request eventually.
module fm_seq_ctrl
    import fm_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rsp_valid,
    output logic             busy,
    output logic [IDX_W-1:0] op_idx,
    output logic             launch,
    output logic             accept,
    output logic             finish
);
    logic [IDX_W-1:0] slot_q;

    // Decode handshake events from the current state
    always_comb begin
        launch = start & ~busy;
        accept = busy & rsp_valid;
        finish = accept & (slot_q == IDX_W'(OPS - 1));
        op_idx = slot_to_op(slot_q);
    end

    // Busy flag and slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            slot_q <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            slot_q <= '0;
        end else if (accept) begin
            if (finish) busy <= 1'b0;
            slot_q <= slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/fm_op_store.sv
// Operator output storage: current-sample value per operator, the value
// from the previous completed sample, and the two-deep operator-1 history.
// Assumes end_smp coincides with the write of the last operator.
module fm_op_store
    import fm_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_op,
    input  op_out_t          wr_data,
    input  logic             end_smp,
    output op_out_t          cur_out  [OPS],
    output op_out_t          last_out [OPS],
    output op_out_t          fb_new,
    output op_out_t          fb_old
);
    for (genvar k = 0; k < OPS; k++) begin : g_op
        // Latest output of operator k and its value one sample back
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_out[k]  <= '0;
                last_out[k] <= '0;
            end else begin
                if (wr_en && wr_op == IDX_W'(k)) cur_out[k] <= wr_data;
                if (end_smp) begin
                    if (k == OPS - 1) last_out[k] <= wr_data;
                    else              last_out[k] <= cur_out[k];
                end
            end
        end
    end

    // Shift operator-1 results into the feedback history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_new <= '0;
            fb_old <= '0;
        end else if (wr_en && wr_op == '0) begin
            fb_new <= wr_data;
            fb_old <= fb_new;
        end
    end
endmodule

// File: rtl/fm_mod_calc.sv
// Phase-offset generator for the requested operator: routed modulator sum
// halved, or for operator 1 the scaled feedback average.
// Assumes the stored outputs are stable while a request is pending.
module fm_mod_calc
    import fm_seq_pkg::*;
(
    input  logic [ALG_W-1:0] alg,
    input  logic [FB_W-1:0]  fb_lvl,
    input  logic [IDX_W-1:0] op_idx,
    input  op_out_t          cur_out  [OPS],
    input  op_out_t          last_out [OPS],
    input  op_out_t          fb_new,
    input  op_out_t          fb_old,
    output logic [PH_W-1:0]  offset
);
    localparam int SH_W = $clog2(PH_W + 1);

    route_t                    rt;
    logic signed [SUM_W-1:0]   term [OPS];
    logic signed [SUM_W-1:0]   mod_sum;
    logic signed [OUT_W:0]     fb_sum;
    logic [SH_W-1:0]           fb_sh;

    // Routing of the requested operator
    always_comb rt = route_of(alg, op_idx);

    for (genvar k = 0; k < OPS; k++) begin : g_term
        // Select current or previous-sample output of modulator k
        always_comb begin
            if (!rt.src[k])     term[k] = '0;
            else if (rt.dly[k]) term[k] = SUM_W'(last_out[k]);
            else                term[k] = SUM_W'(cur_out[k]);
        end
    end

    // Add up the modulator terms
    always_comb begin
        mod_sum = '0;
        for (int k = 0; k < OPS; k++) mod_sum = mod_sum + term[k];
    end

    // Feedback sum and shift amount
    always_comb begin
        fb_sum = (OUT_W + 1)'(fb_new) + (OUT_W + 1)'(fb_old);
        fb_sh  = SH_W'(PH_W) - SH_W'(fb_lvl);
    end

    // Final offset: feedback for operator 1, halved modulator sum otherwise
    always_comb begin
        if (op_idx == '0) offset = (fb_lvl == '0) ? '0 : PH_W'(fb_sum >>> fb_sh);
        else              offset = PH_W'(mod_sum >>> 1);
    end
endmodule

// File: rtl/fm_carrier_sum.sv
// Carrier mixer: adds the carrier outputs of the algorithm and saturates
// to the operator output range. Purely combinational.
module fm_carrier_sum
    import fm_seq_pkg::*;
(
    input  logic [ALG_W-1:0] alg,
    input  op_out_t          car_in [OPS],
    output op_out_t          sample
);
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = SUM_W'(-(1 << (OUT_W - 1)));

    logic [OPS-1:0]          car_mask;
    logic signed [SUM_W-1:0] total;

    // Sum the selected carriers at full width
    always_comb begin
        car_mask = carriers_of(alg);
        total    = '0;
        for (int k = 0; k < OPS; k++)
            if (car_mask[k]) total = total + SUM_W'(car_in[k]);
    end

    // Clamp to the signed operator range
    always_comb begin
        if (total > HI)      sample = {1'b0, {(OUT_W - 1){1'b1}}};
        else if (total < LO) sample = {1'b1, {(OUT_W - 1){1'b0}}};
        else                 sample = OUT_W'(total);
    end
endmodule

// File: rtl/fm_alg_seq.sv
// Top of the four-operator FM algorithm sequencer. Latches the channel
// configuration at sample start, issues operator requests with phase
// offsets, stores results and registers the saturated channel sample.
// Assumes one outstanding request and an operator unit that always answers.
module fm_alg_seq
    import fm_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CFG_W-1:0]        chan_cfg,
    input  logic                    smp_start,
    output logic                    op_req_valid,
    output logic [IDX_W-1:0]        op_req_idx,
    output logic [PH_W-1:0]         op_req_offset,
    input  logic                    op_rsp_valid,
    input  logic signed [OUT_W-1:0] op_rsp_data,
    output logic                    smp_valid,
    output logic signed [OUT_W-1:0] smp_data
);
    logic             busy, launch, accept, finish;
    logic [IDX_W-1:0] op_idx;
    logic [ALG_W-1:0] alg_q;
    logic [FB_W-1:0]  fb_q;
    op_out_t          cur_out  [OPS];
    op_out_t          last_out [OPS];
    op_out_t          car_in   [OPS];
    op_out_t          fb_new, fb_old, mix;

    fm_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(smp_start), .rsp_valid(op_rsp_valid),
        .busy(busy), .op_idx(op_idx), .launch(launch), .accept(accept),
        .finish(finish)
    );

    // Capture algorithm and feedback level when a sample starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alg_q <= '0;
            fb_q  <= '0;
        end else if (launch) begin
            alg_q <= chan_cfg[ALG_W-1:0];
            fb_q  <= chan_cfg[CFG_W-1:ALG_W];
        end
    end

    fm_op_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_op(op_idx),
        .wr_data(op_rsp_data), .end_smp(finish), .cur_out(cur_out),
        .last_out(last_out), .fb_new(fb_new), .fb_old(fb_old)
    );

    fm_mod_calc u_mod (
        .alg(alg_q), .fb_lvl(fb_q), .op_idx(op_idx), .cur_out(cur_out),
        .last_out(last_out), .fb_new(fb_new), .fb_old(fb_old),
        .offset(op_req_offset)
    );

    // Carrier inputs: stored operators 1-3, live response for operator 4
    for (genvar k = 0; k < OPS; k++) begin : g_car
        if (k == OPS - 1) begin : g_live
            always_comb car_in[k] = op_rsp_data;
        end else begin : g_held
            always_comb car_in[k] = cur_out[k];
        end
    end

    fm_carrier_sum u_mix (.alg(alg_q), .car_in(car_in), .sample(mix));

    // Request outputs follow the sequencer
    always_comb begin
        op_req_valid = busy;
        op_req_idx   = op_idx;
    end

    // Register the channel sample on the last response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= finish;
            if (finish) smp_data <= mix;
        end
    end
endmodule

// File: rtl/fm_alg_seq_chk.sv
// Protocol checker for fm_alg_seq, bound to every instance.
module fm_alg_seq_chk
    import fm_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_req_valid,
    input logic [IDX_W-1:0] op_req_idx,
    input logic [PH_W-1:0]  op_req_offset,
    input logic             op_rsp_valid,
    input logic             smp_valid
);
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_valid && !op_rsp_valid |=>
            op_req_valid && $stable(op_req_idx) && $stable(op_req_offset));

    a_r2_op1_then_op3: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_valid && op_rsp_valid && op_req_idx == 2'd0 |=>
            op_req_valid && op_req_idx == 2'd2);

    a_r2_op3_then_op2: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_valid && op_rsp_valid && op_req_idx == 2'd2 |=>
            op_req_valid && op_req_idx == 2'd1);

    a_r2_op2_then_op4: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_valid && op_rsp_valid && op_req_idx == 2'd1 |=>
            op_req_valid && op_req_idx == 2'd3);

    a_r8_sample_after_op4: assert property (@(posedge clk) disable iff (!rst_n)
        op_req_valid && op_rsp_valid && op_req_idx == 2'd3 |=>
            smp_valid && !op_req_valid);

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
endmodule

bind fm_alg_seq fm_alg_seq_chk u_chk (.*);

// File: tb/fm_alg_seq_bench.sv
module fm_alg_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        chan_cfg = '0;
    logic              smp_start = 1'b0;
    logic              op_req_valid;
    logic [1:0]        op_req_idx;
    logic [9:0]        op_req_offset;
    logic              op_rsp_valid = 1'b0;
    logic signed [13:0] op_rsp_data = '0;
    logic              smp_valid;
    logic signed [13:0] smp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int m_cur [4];
    int m_last[4];
    int m_fb0, m_fb1;

    fm_alg_seq u_fm_alg_seq (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected phase offset from the requirements (R4, R5, R6)
    function automatic int exp_off(input int alg, input int fb, input int op);
        int s = 0;
        if (op == 0) begin
            if (fb == 0) return 0;
            return ((m_fb0 + m_fb1) >>> (10 - fb)) & 1023;
        end
        case (alg)
            0: s = (op == 1) ? m_cur[0] : (op == 2) ? m_last[1] : m_cur[2];
            1: s = (op == 1) ? 0 : (op == 2) ? m_last[0] + m_last[1] : m_cur[2];
            2: s = (op == 1) ? 0 : (op == 2) ? m_last[1] : m_cur[0] + m_cur[2];
            3: s = (op == 1) ? m_cur[0] : (op == 2) ? 0 : m_last[1] + m_cur[2];
            4: s = (op == 1) ? m_cur[0] : (op == 2) ? 0 : m_cur[2];
            5: s = (op == 2) ? m_last[0] : m_cur[0];
            6: s = (op == 1) ? m_cur[0] : 0;
            default: s = 0;
        endcase
        return (s >>> 1) & 1023;
    endfunction

    // Expected saturated channel sample (R7)
    function automatic int exp_smp(input int alg);
        int s;
        case (alg)
            0, 1, 2, 3: s = m_cur[3];
            4:          s = m_cur[1] + m_cur[3];
            5, 6:       s = m_cur[1] + m_cur[2] + m_cur[3];
            default:    s = m_cur[0] + m_cur[1] + m_cur[2] + m_cur[3];
        endcase
        if (s > 8191)  s = 8191;
        if (s < -8192) s = -8192;
        return s;
    endfunction

    // One sample period acting as the operator unit; poke tests R9
    task automatic run_sample(input int alg, input int fb, input int v0,
                              input int v1, input int v2, input int v3,
                              input bit poke);
        int vals[4];
        int ord[4];
        vals = '{v0, v1, v2, v3};
        ord  = '{0, 2, 1, 3};
        @(negedge clk);
        chan_cfg  = 6'((fb << 3) | alg);
        smp_start = 1'b1;
        @(negedge clk);
        smp_start = 1'b0;
        for (int s = 0; s < 4; s++) begin
            int w = 0;
            int op = ord[s];
            int d;
            int exp_o;
            while (!op_req_valid && w < 20) begin
                @(negedge clk);
                w++;
            end
            exp_o = exp_off(alg, fb, op);
            check("R2 request index", int'(op_req_idx), op);
            check("R4 R5 R6 phase offset", int'(op_req_offset), exp_o);
            d = (poke && s == 1) ? 2 : int'($urandom_range(0, 2));
            for (int j = 0; j < d; j++) begin
                if (poke && s == 1 && j == 0) begin
                    smp_start = 1'b1;
                    chan_cfg  = ~chan_cfg;
                end
                @(negedge clk);
                smp_start = 1'b0;
                check("R3 request held", int'(op_req_valid), 1);
                check("R3 index held", int'(op_req_idx), op);
                check("R3 offset held", int'(op_req_offset), exp_o);
            end
            op_rsp_valid = 1'b1;
            op_rsp_data  = 14'(vals[op]);
            m_cur[op] = vals[op];
            if (op == 0) begin
                m_fb1 = m_fb0;
                m_fb0 = vals[op];
            end
            @(negedge clk);
            op_rsp_valid = 1'b0;
        end
        check("R8 sample strobe", int'(smp_valid), 1);
        check("R7 channel sample", int'(smp_data), exp_smp(alg));
        for (int k = 0; k < 4; k++) m_last[k] = m_cur[k];
        @(negedge clk);
        check("R8 strobe one cycle", int'(smp_valid), 0);
        check("R2 R9 no extra request", int'(op_req_valid), 0);
    endtask

    function automatic int rnd14();
        return int'($urandom_range(0, 16383)) - 8192;
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 4; k++) begin
            m_cur[k]  = 0;
            m_last[k] = 0;
        end
        m_fb0 = 0;
        m_fb1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset request", int'(op_req_valid), 0);
        check("R1 reset strobe", int'(smp_valid), 0);
        check("R1 reset sample", int'(smp_data), 0);

        // R1: history zero, feedback at maximum still gives zero offset
        run_sample(0, 7, 1000, -2000, 3000, -4000, 1'b0);

        // R9: response while idle must not touch stored state
        @(negedge clk);
        op_rsp_valid = 1'b1;
        op_rsp_data  = 14'sd5555;
        @(negedge clk);
        op_rsp_valid = 1'b0;
        check("R9 idle response ignored", int'(smp_valid), 0);
        run_sample(1, 7, 8191, 8191, -8192, 100, 1'b0);

        // R7: saturation at both rails and in two-carrier mode
        run_sample(7, 0, 8191, 8191, 8191, 8191, 1'b0);
        run_sample(7, 0, -8192, -8192, -8192, -8192, 1'b0);
        run_sample(4, 3, 0, 8000, 0, 8000, 1'b0);
        run_sample(5, 1, 5, -8000, -8000, -8000, 1'b0);

        // R6: feedback extremes at every level
        for (int f = 0; f < 8; f++) run_sample(6, f, 8191, 7, -9, 11, 1'b0);
        for (int f = 0; f < 8; f++) run_sample(2, f, -8192, 3, 1, -1, 1'b0);

        // R9: start and configuration change while busy
        run_sample(3, 5, 1234, -4321, 2222, 77, 1'b1);
        run_sample(0, 2, -600, 7000, -7000, 6000, 1'b1);

        // R4 R5: random algorithms, levels and outputs
        for (int n = 0; n < 400; n++)
            run_sample(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                       rnd14(), rnd14(), rnd14(), rnd14(), ($urandom_range(0, 9) == 0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule